// File: doc/BRIEF.md
# Multi-Channel Interrupt Source Aggregator

This block gathers the interrupt requests of eight serial channels and one timer into a window of four read-only byte registers on a parallel host bus. Each channel presents six request inputs: receive data ready, four receive line error flags (parity, framing, overrun, break), receive timeout, transmit ready, modem status change and special character match. A priority encoder per channel reduces these to a 3-bit source code. A single active-low interrupt line tells the host that something is pending.

The first register of the window is a summary with one pending bit per channel. The next three registers hold the eight 3-bit codes packed end to end, so several fields cross a byte boundary. The host reads the summary first. That read freezes a copy of all eight codes, so the three code bytes that follow stay consistent with one another and with the summary, even when sources change between the byte reads. Request lines are levels. Clearing a source, for example by draining receive data, happens in the channel, which then drops its line.

Top module: `irq_agg`

## Requirements
- R1: After reset, `irq_n` is high, `rdata` is 0x00, and a read of any code register returns 0x00 until the summary register has been read.
- R2: A read of the summary at address 0x80 returns bit n set exactly when channel n had at least one request input high at the clock edge before the read edge. Bit 7 is channel 7.
- R3: The source code of a channel is 1 when receive data ready or any of its four line error flags is high. Otherwise it is 2 for receive timeout, then 3 for transmit ready, then 4 for modem status, then 5 for special character, and 0 when nothing is requested. Only the highest active source is reported.
- R4: The concatenation {reg 0x81, reg 0x82, reg 0x83} is a 24-bit word. Channel c's code occupies bits [23-3c : 21-3c] with its MSB at the higher bit. Channel 2 therefore covers 0x81 bits 1:0 and 0x82 bit 7, and channel 5 covers 0x82 bit 0 and 0x83 bits 7:6.
- R5: A read of 0x80 captures all eight codes. Reads of 0x81 to 0x83 return that capture and are unaffected by source changes made after it.
- R6: `irq_n` is low exactly when any channel pending bit or `timer_irq` was high at the previous clock edge. The timer alone drives `irq_n` low without setting any summary bit.
- R7: A read strobe at any address outside 0x80 to 0x83 returns 0x00.
- R8: `rdata` changes only on a clock edge where `cs` and `rd` are both high. Otherwise it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs | input | 1 | Chip select for a bus read |
| rd | input | 1 | Read strobe, sampled together with `cs` |
| addr | input | 8 | Byte address |
| rdata | output | 8 | Registered read data, valid the cycle after the strobe |
| ch_rx_ready | input | 8 | Receive data ready per channel |
| ch_line_err | input | 32 | Four line error flags per channel, channel c at bits [4c+3:4c] |
| ch_rx_tmo | input | 8 | Receive timeout per channel |
| ch_tx_rdy | input | 8 | Transmit ready per channel |
| ch_modem | input | 8 | Modem status change per channel |
| ch_special | input | 8 | Special character match per channel |
| timer_irq | input | 1 | Timer interrupt request |
| irq_n | output | 1 | Combined interrupt, active low |

## Verification
The bench builds the block with its defaults: eight channels, 3-bit codes, an 8-bit address and the window at 0x80. This is the one shape in which fields straddle two byte boundaries, so the split fields of channels 2 and 5 are exercised with patterns that put ones in the crossing bits. With 24 packed bits the code bytes carry no padding, so every bit of every code byte is compared. The 8-bit address also lets reads just below and just above the window be issued.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int SRC_W = 3;
  localparam int LERR_W = 4;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE   = 3'd0,
    SRC_RXDATA = 3'd1,
    SRC_RXTMO  = 3'd2,
    SRC_TXRDY  = 3'd3,
    SRC_MODEM  = 3'd4,
    SRC_SPCHR  = 3'd5
  } src_code_e;
endpackage

// File: rtl/irq_src_enc.sv
module irq_src_enc
  import irq_agg_pkg::*;
(
  input  logic              rx_ready,
  input  logic [LERR_W-1:0] line_err,
  input  logic              rx_tmo,
  input  logic              tx_rdy,
  input  logic              modem,
  input  logic              special,
  output logic [SRC_W-1:0]  code,
  output logic              active
);
  src_code_e sel;

  // fixed priority, receive path first
  always_comb begin
    if (rx_ready || (|line_err)) sel = SRC_RXDATA;
    else if (rx_tmo)             sel = SRC_RXTMO;
    else if (tx_rdy)             sel = SRC_TXRDY;
    else if (modem)              sel = SRC_MODEM;
    else if (special)            sel = SRC_SPCHR;
    else                         sel = SRC_NONE;
  end

  assign code   = sel;
  assign active = (sel != SRC_NONE);
endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank
  import irq_agg_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 8,
  localparam int PACK_BITS  = NCH * SRC_W,
  localparam int PACK_BYTES = (PACK_BITS + DW - 1) / DW,
  localparam int PACK_PAD   = PACK_BYTES * DW - PACK_BITS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCH-1:0]           ch_active,
  input  logic [NCH*SRC_W-1:0]     ch_code,
  input  logic                     timer_in,
  input  logic                     snap_en,
  output logic [NCH-1:0]           pend_q,
  output logic                     timer_q,
  output logic [PACK_BYTES*DW-1:0] snap_q
);
  logic [PACK_BYTES*DW-1:0] live_d, live_q, snap_d;

  // channel 0 lands in the most significant field
  for (genvar c = 0; c < NCH; c++) begin : g_pack
    assign live_d[PACK_BYTES*DW-1-c*SRC_W -: SRC_W] = ch_code[c*SRC_W +: SRC_W];
  end
  if (PACK_PAD > 0) begin : g_pad
    assign live_d[PACK_PAD-1:0] = '0;
  end

  always_comb begin
    snap_d = snap_q;
    if (snap_en) snap_d = live_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      timer_q <= 1'b0;
      live_q  <= '0;
      snap_q  <= '0;
    end else begin
      pend_q  <= ch_active;
      timer_q <= timer_in;
      live_q  <= live_d;
      snap_q  <= snap_d;
    end
  end
endmodule

// File: rtl/irq_rd_port.sv
module irq_rd_port #(
  parameter int          ADDR_W     = 8,
  parameter int          DW         = 8,
  parameter int          NCH        = 8,
  parameter int          PACK_BYTES = 3,
  parameter logic [31:0] BASE       = 32'h80
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs,
  input  logic                     rd,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NCH-1:0]           pend,
  input  logic [PACK_BYTES*DW-1:0] snap,
  output logic                     snap_en,
  output logic [DW-1:0]            rdata
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(PACK_BYTES + 1);

  logic              strobe, in_win;
  logic [ADDR_W-1:0] ofs;
  logic [DW-1:0]     sum_byte, rdata_d;

  assign strobe  = cs && rd;
  assign ofs     = addr - BASE_A;
  assign in_win  = (addr >= BASE_A) && (ofs < NREG_A);
  assign snap_en = strobe && (addr == BASE_A);

  always_comb begin
    sum_byte = '0;
    sum_byte[NCH-1:0] = pend;
  end

  always_comb begin
    rdata_d = rdata;
    if (strobe) begin
      rdata_d = '0;
      if (in_win) begin
        if (ofs == '0) rdata_d = sum_byte;
        for (int j = 0; j < PACK_BYTES; j++) begin
          if (ofs == ADDR_W'(j + 1)) rdata_d = snap[(PACK_BYTES-1-j)*DW +: DW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int          NCH    = 8,
  parameter int          ADDR_W = 8,
  parameter int          DW     = 8,
  parameter logic [31:0] BASE   = 32'h80,
  localparam int PACK_BYTES = (NCH * SRC_W + DW - 1) / DW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs,
  input  logic                  rd,
  input  logic [ADDR_W-1:0]     addr,
  output logic [DW-1:0]         rdata,
  input  logic [NCH-1:0]        ch_rx_ready,
  input  logic [NCH*LERR_W-1:0] ch_line_err,
  input  logic [NCH-1:0]        ch_rx_tmo,
  input  logic [NCH-1:0]        ch_tx_rdy,
  input  logic [NCH-1:0]        ch_modem,
  input  logic [NCH-1:0]        ch_special,
  input  logic                  timer_irq,
  output logic                  irq_n
);
  logic [1:0]               rst_sync;
  logic                     rst_i_n;
  logic [NCH-1:0]           act, pend_q;
  logic [NCH*SRC_W-1:0]     codes;
  logic                     timer_q, snap_en;
  logic [PACK_BYTES*DW-1:0] snap_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    irq_src_enc u_enc (
      .rx_ready (ch_rx_ready[c]),
      .line_err (ch_line_err[c*LERR_W +: LERR_W]),
      .rx_tmo   (ch_rx_tmo[c]),
      .tx_rdy   (ch_tx_rdy[c]),
      .modem    (ch_modem[c]),
      .special  (ch_special[c]),
      .code     (codes[c*SRC_W +: SRC_W]),
      .active   (act[c])
    );
  end

  irq_stat_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .ch_active (act),
    .ch_code   (codes),
    .timer_in  (timer_irq),
    .snap_en   (snap_en),
    .pend_q    (pend_q),
    .timer_q   (timer_q),
    .snap_q    (snap_q)
  );

  irq_rd_port #(
    .ADDR_W(ADDR_W), .DW(DW), .NCH(NCH), .PACK_BYTES(PACK_BYTES), .BASE(BASE)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .cs      (cs),
    .rd      (rd),
    .addr    (addr),
    .pend    (pend_q),
    .snap    (snap_q),
    .snap_en (snap_en),
    .rdata   (rdata)
  );

  assign irq_n = ~((|pend_q) | timer_q);
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int          NCH    = 8,
  parameter int          ADDR_W = 8,
  parameter int          DW     = 8,
  parameter logic [31:0] BASE   = 32'h80
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              rd,
  input logic [ADDR_W-1:0] addr,
  input logic [DW-1:0]     rdata,
  input logic [NCH-1:0]    ch_rx_ready,
  input logic              timer_irq,
  input logic              irq_n
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(BASE + 3);

  // R6
  timer_irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer_irq |=> !irq_n);

  // R7
  out_of_window_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && ((addr < BASE_A) || (addr > LAST_A))) |=> (rdata == '0));

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |=> $stable(rdata));

  // R2
  summary_all_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && (addr == BASE_A) && $past(&ch_rx_ready) && $past(rst_n))
      |=> (rdata[NCH-1:0] == {NCH{1'b1}}));
endmodule

bind irq_agg irq_agg_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .DW(DW), .BASE(BASE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_i_n),
  .cs          (cs),
  .rd          (rd),
  .addr        (addr),
  .rdata       (rdata),
  .ch_rx_ready (ch_rx_ready),
  .timer_irq   (timer_irq),
  .irq_n       (irq_n)
);

// File: tb/sim_irq_agg.sv
module sim_irq_agg;
  localparam int CLK_P = 10;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] rdata;
  logic [NCH-1:0] rx_ready = '0, rx_tmo = '0, tx_rdy = '0, modem = '0, special = '0;
  logic [NCH*4-1:0] line_err = '0;
  logic timer_irq = 1'b0;
  logic irq_n;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [23:0] exp_snap = '0;

  always #(CLK_P/2) clk = ~clk;

  irq_agg u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .addr(addr), .rdata(rdata),
    .ch_rx_ready(rx_ready), .ch_line_err(line_err), .ch_rx_tmo(rx_tmo),
    .ch_tx_rdy(tx_rdy), .ch_modem(modem), .ch_special(special),
    .timer_irq(timer_irq), .irq_n(irq_n)
  );

  function automatic logic [2:0] code_of(int c);
    if (rx_ready[c] || line_err[c*4 +: 4] != 0) return 3'd1;
    if (rx_tmo[c])  return 3'd2;
    if (tx_rdy[c])  return 3'd3;
    if (modem[c])   return 3'd4;
    if (special[c]) return 3'd5;
    return 3'd0;
  endfunction

  function automatic logic [23:0] pack_now();
    logic [23:0] p = '0;
    for (int c = 0; c < NCH; c++) p[23-3*c -: 3] = code_of(c);
    return p;
  endfunction

  function automatic logic [7:0] summary_now();
    logic [7:0] s = '0;
    for (int c = 0; c < NCH; c++) s[c] = (code_of(c) != 3'd0);
    return s;
  endfunction

  task automatic check(logic [7:0] act, logic [7:0] exp, string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // driver: queues the expected byte and issues one read strobe
  task automatic rd_byte(logic [7:0] a, string tag);
    logic [7:0] e;
    @(negedge clk);
    if (a == 8'h80) begin
      e = summary_now();
      exp_snap = pack_now();
    end else if (a == 8'h81) e = exp_snap[23:16];
    else if (a == 8'h82) e = exp_snap[15:8];
    else if (a == 8'h83) e = exp_snap[7:0];
    else e = 8'h00;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    cs = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic rd_window(string tag);
    rd_byte(8'h80, {tag, " R2 summary"});
    rd_byte(8'h81, {tag, " R3 R4 byte81"});
    rd_byte(8'h82, {tag, " R3 R4 byte82"});
    rd_byte(8'h83, {tag, " R3 R4 byte83"});
  endtask

  task automatic chk_irq(string tag);
    @(negedge clk);
    check({7'd0, irq_n}, {7'd0, ~((summary_now() != 0) | timer_irq)}, tag);
  endtask

  task automatic clear_src();
    @(negedge clk);
    rx_ready = '0; rx_tmo = '0; tx_rdy = '0; modem = '0; special = '0;
    line_err = '0; timer_irq = 1'b0;
  endtask

  // monitor: compares rdata one edge after each strobe
  always @(posedge clk) begin
    #1;
    if (cs && rd) begin
      if (exp_q.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL scoreboard: actual %02h expected none", rdata);
      end else begin
        check(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(rdata, 8'h00, "R1 rdata after reset");
    check({7'd0, irq_n}, 8'h01, "R1 irq_n after reset");
    rd_byte(8'h81, "R1 code byte before summary read");

    // R2 R6 single channel
    @(negedge clk); rx_ready[0] = 1'b1;
    chk_irq("R6 irq from channel 0");
    rd_window("single ch0");

    // R3 distinct codes per channel
    clear_src();
    @(negedge clk);
    special[0] = 1; modem[1] = 1; special[1] = 1; tx_rdy[2] = 1; modem[2] = 1;
    rx_tmo[3] = 1; tx_rdy[3] = 1; line_err[4*4+2] = 1; rx_tmo[4] = 1;
    rx_ready[5] = 1; special[5] = 1; special[7] = 1;
    rd_window("mixed priority");

    // R4 straddling field of channel 2 with pattern 101
    clear_src(); @(negedge clk); special[2] = 1;
    rd_window("straddle ch2");
    // R4 channel 5 field pattern 011
    clear_src(); @(negedge clk); tx_rdy[5] = 1;
    rd_window("straddle ch5");
    // R3 every line flag alone maps to code 1
    for (int b = 0; b < 4; b++) begin
      clear_src(); @(negedge clk); line_err[6*4+b] = 1; special[6] = 1;
      rd_window("line flag ch6");
    end
    // R2 all channels busy
    clear_src(); @(negedge clk); rx_ready = '1; modem = '1;
    rd_window("all channels");

    // R5 capture survives later source changes
    clear_src(); @(negedge clk); modem[3] = 1; tx_rdy[6] = 1;
    rd_byte(8'h80, "R5 capture");
    @(negedge clk); modem = '0; tx_rdy = '0; rx_ready = '1;
    rd_byte(8'h81, "R5 frozen 81");
    rd_byte(8'h82, "R5 frozen 82");
    rd_byte(8'h83, "R5 frozen 83");

    // R6 timer alone
    clear_src(); @(negedge clk); timer_irq = 1'b1;
    chk_irq("R6 timer only");
    rd_byte(8'h80, "R6 timer leaves summary clear");
    clear_src();
    chk_irq("R6 idle release");

    // R7 out of window
    @(negedge clk); rx_ready[4] = 1;
    rd_byte(8'h84, "R7 above window");
    rd_byte(8'h7F, "R7 below window");
    rd_byte(8'h00, "R7 address zero");

    // R8 rdata holds without a strobe
    rd_byte(8'h80, "R8 setup read");
    held = rdata;
    @(negedge clk); rx_ready = '0; special = 8'hA5;
    @(negedge clk); cs = 1'b1; addr = 8'h80;
    @(negedge clk); cs = 1'b0; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    repeat (2) @(negedge clk);
    check(rdata, held, "R8 rdata held");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule